// File: doc/BRIEF.md
# Square-root carry-select adder

This block adds two unsigned operands and a single carry bit in one combinational pass, giving a sum of the operand width and a carry-out. The operand is cut into contiguous groups whose widths grow by one bit per group toward the most significant end. With the default parameters these are five groups covering bits 0-1, 2-4, 5-8, 9-13 and 14-19, for a 20-bit datapath.

A first stage forms the per-bit propagate (XOR) and generate (AND) terms. Every group above the lowest then runs two ripple chains side by side, one seeded with a zero carry and one seeded with a one. When the real carry reaches the group boundary, it only steers a multiplexer. The lowest group has no speculation: it ripples straight from the external carry-in.

The growing widths balance each group's internal chain against the time its select takes to arrive. A wider upper group has longer to finish both of its chains before its boundary carry is known.

Top module: `sqrtSelectAdder`

## Requirements
- R1: `{carryOut, sumOut}` equals the unsigned value `opA + opB + carryIn` for every input combination, with `carryOut` as bit WIDTH of the 21-bit result.
- R2: Group k starts at bit `k*FIRST_WIDTH + k*(k-1)/2` and is `FIRST_WIDTH + k` bits wide. The defaults give boundaries at bits 2, 5, 9 and 14, and a carry entering any boundary lands in the correct sum bit.
- R3: Every group above the lowest computes a result for an incoming carry of 0 and one for an incoming carry of 1. A group whose bits all propagate passes the incoming carry through, and a group that generates yields a carry under either seed.
- R4: The carry selected at the top of each group is the select of the next more significant group, so the carry entering every boundary equals the true arithmetic carry into that bit.
- R5: The lowest group ripples directly from `carryIn` with no speculative copy, so `carryIn` alone increments the sum, and a carry out of bit 1 enters bit 2.
- R6: `carryOut` is the carry selected at the top of the most significant group. It is set exactly when the true sum exceeds `2**WIDTH - 1`.
- R7: When every bit propagates (`opA ^ opB` all ones), the sum is all ones with `carryOut` 0 for `carryIn` 0. It is all zeros with `carryOut` 1 for `carryIn` 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH (20) | First addend |
| opB | input | WIDTH (20) | Second addend |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | WIDTH (20) | Sum bits |
| carryOut | output | 1 | Carry out of the top bit |

## Verification
The block holds no state, so a wrong speculative carry or a misplaced boundary shows at the ports in the same evaluation. It only shows when the incoming carry selects the faulty path. A broken carry-1 chain in a group stays hidden while that group's incoming carry is 0. The directed patterns therefore force each group's boundary carry to both values, using all-propagate and all-generate slices. Random patterns biased toward long propagate runs then cover mixed cases.

// File: rtl/sqsel_pkg.sv
`timescale 1ns/1ps
package sqsel_pkg;
  // Lowest bit of group k when group widths are firstW, firstW+1, ...
  function automatic int grpLsb(input int firstW, input int k);
    return k * firstW + (k * (k - 1)) / 2;
  endfunction

  // Width of group k
  function automatic int grpWidth(input int firstW, input int k);
    return firstW + k;
  endfunction
endpackage

// File: rtl/csa_pg_setup.sv
`timescale 1ns/1ps
// Per-bit propagate / generate terms feeding every carry chain.
module csaPgSetup #(
  parameter int WIDTH = 20
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] prop,
  output logic [WIDTH-1:0] gen
);
  assign prop = opA ^ opB;
  assign gen  = opA & opB;
endmodule

// File: rtl/csa_ripple.sv
`timescale 1ns/1ps
// Plain ripple chain over one group, seeded with a given carry.
module csaRipple #(
  parameter int W = 2
) (
  input  logic         seed,
  input  logic [W-1:0] prop,
  input  logic [W-1:0] gen,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic chainC;

  always_comb begin
    chainC = seed;
    for (int i = 0; i < W; i++) begin
      sum[i] = prop[i] ^ chainC;
      chainC = gen[i] | (prop[i] & chainC);
    end
    cout = chainC;
  end
endmodule

// File: rtl/csa_spec_group.sv
`timescale 1ns/1ps
// Speculative group: two chains, one assuming carry 0, one assuming carry 1.
module csaSpecGroup #(
  parameter int W = 3
) (
  input  logic [W-1:0] prop,
  input  logic [W-1:0] gen,
  output logic [W-1:0] sumLow,
  output logic [W-1:0] sumHigh,
  output logic         coutLow,
  output logic         coutHigh
);
  csaRipple #(.W(W)) uChainLow (
    .seed(1'b0),
    .prop(prop),
    .gen (gen),
    .sum (sumLow),
    .cout(coutLow)
  );

  csaRipple #(.W(W)) uChainHigh (
    .seed(1'b1),
    .prop(prop),
    .gen (gen),
    .sum (sumHigh),
    .cout(coutHigh)
  );
endmodule

// File: rtl/csa_select_chain.sv
`timescale 1ns/1ps
// Control path: walks the real carry across group boundaries and emits the
// per-group select strobes that steer the datapath multiplexers.
module csaSelectChain #(
  parameter int NUM_GROUPS = 5
) (
  input  logic                  carryIn,
  input  logic [NUM_GROUPS-1:0] specCout0,
  input  logic [NUM_GROUPS-1:0] specCout1,
  output logic [NUM_GROUPS-1:0] groupSel,
  output logic [NUM_GROUPS:0]   boundaryCarry
);
  logic walkC;

  always_comb begin
    walkC            = carryIn;
    boundaryCarry[0] = walkC;
    for (int k = 0; k < NUM_GROUPS; k++) begin
      groupSel[k]        = walkC;
      walkC              = walkC ? specCout1[k] : specCout0[k];
      boundaryCarry[k+1] = walkC;
    end
  end
endmodule

// File: rtl/sqrt_select_adder.sv
`timescale 1ns/1ps
// Carry-select adder with group widths growing by one bit per group.
module sqrtSelectAdder #(
  parameter  int FIRST_WIDTH = 2,
  parameter  int NUM_GROUPS  = 5,
  localparam int WIDTH       = sqsel_pkg::grpLsb(FIRST_WIDTH, NUM_GROUPS)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  logic [WIDTH-1:0]      prop;
  logic [WIDTH-1:0]      gen;
  logic [WIDTH-1:0]      sumLow;
  logic [WIDTH-1:0]      sumHigh;
  logic [NUM_GROUPS-1:0] specCout0;
  logic [NUM_GROUPS-1:0] specCout1;
  logic [NUM_GROUPS-1:0] groupSel;
  logic [NUM_GROUPS:0]   boundaryCarry;

  csaPgSetup #(.WIDTH(WIDTH)) uPg (
    .opA (opA),
    .opB (opB),
    .prop(prop),
    .gen (gen)
  );

  for (genvar k = 0; k < NUM_GROUPS; k++) begin : gGroup
    localparam int LSB = sqsel_pkg::grpLsb(FIRST_WIDTH, k);
    localparam int W   = sqsel_pkg::grpWidth(FIRST_WIDTH, k);

    if (k == 0) begin : gDirect
      // Lowest group: real carry is available at once, no speculation.
      csaRipple #(.W(W)) uLow (
        .seed(carryIn),
        .prop(prop[LSB +: W]),
        .gen (gen[LSB +: W]),
        .sum (sumLow[LSB +: W]),
        .cout(specCout0[k])
      );
      assign sumHigh[LSB +: W] = sumLow[LSB +: W];
      assign specCout1[k]      = specCout0[k];
    end else begin : gSpec
      csaSpecGroup #(.W(W)) uSpec (
        .prop    (prop[LSB +: W]),
        .gen     (gen[LSB +: W]),
        .sumLow  (sumLow[LSB +: W]),
        .sumHigh (sumHigh[LSB +: W]),
        .coutLow (specCout0[k]),
        .coutHigh(specCout1[k])
      );
    end

    // Sum multiplexer steered by the select strobe for this group
    assign sumOut[LSB +: W] = groupSel[k] ? sumHigh[LSB +: W] : sumLow[LSB +: W];
  end

  csaSelectChain #(.NUM_GROUPS(NUM_GROUPS)) uSel (
    .carryIn      (carryIn),
    .specCout0    (specCout0),
    .specCout1    (specCout1),
    .groupSel     (groupSel),
    .boundaryCarry(boundaryCarry)
  );

  assign carryOut = boundaryCarry[NUM_GROUPS];
endmodule

// File: rtl/csa_checker.sv
`timescale 1ns/1ps
// Property checker for sqrtSelectAdder, attached through bind.
module csaChecker #(
  parameter  int FIRST_WIDTH = 2,
  parameter  int NUM_GROUPS  = 5,
  localparam int WIDTH       = sqsel_pkg::grpLsb(FIRST_WIDTH, NUM_GROUPS)
) (
  input logic [WIDTH-1:0]      opA,
  input logic [WIDTH-1:0]      opB,
  input logic                  carryIn,
  input logic [WIDTH-1:0]      sumOut,
  input logic                  carryOut,
  input logic [NUM_GROUPS-1:0] specCout0,
  input logic [NUM_GROUPS-1:0] specCout1,
  input logic [NUM_GROUPS:0]   boundaryCarry
);
  logic [WIDTH:0]   refFull;
  logic [WIDTH:0]   partial;
  logic [WIDTH-1:0] lowMask;
  logic [WIDTH-1:0] sliceMask;
  logic [WIDTH-1:0] aSlice;
  logic [WIDTH-1:0] bSlice;
  logic [WIDTH:0]   spec0;
  logic [WIDTH:0]   spec1;
  int               lsb;
  int               wk;

  always_comb begin
    refFull = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};
    AST_SUM_EXACT: assert ({carryOut, sumOut} == refFull) else $error("sum mismatch"); // R1

    for (int k = 0; k <= NUM_GROUPS; k++) begin
      lsb     = sqsel_pkg::grpLsb(FIRST_WIDTH, k);
      lowMask = {WIDTH{1'b1}} >> (WIDTH - lsb);
      partial = {1'b0, opA & lowMask} + {1'b0, opB & lowMask} + {{WIDTH{1'b0}}, carryIn};
      AST_BOUNDARY_TRUE: assert (boundaryCarry[k] == partial[lsb]) else $error("boundary carry wrong"); // R4
    end

    for (int k = 1; k < NUM_GROUPS; k++) begin
      lsb       = sqsel_pkg::grpLsb(FIRST_WIDTH, k);
      wk        = sqsel_pkg::grpWidth(FIRST_WIDTH, k);
      sliceMask = {WIDTH{1'b1}} >> (WIDTH - wk);
      aSlice    = (opA >> lsb) & sliceMask;
      bSlice    = (opB >> lsb) & sliceMask;
      spec0     = {1'b0, aSlice} + {1'b0, bSlice};
      spec1     = {1'b0, aSlice} + {1'b0, bSlice} + {{WIDTH{1'b0}}, 1'b1};
      AST_SPEC_LOW: assert (specCout0[k] == spec0[wk]) else $error("carry-0 chain wrong"); // R3
      AST_SPEC_HIGH: assert (specCout1[k] == spec1[wk]) else $error("carry-1 chain wrong"); // R3
      AST_SPEC_ORDER: assert (!specCout0[k] || specCout1[k]) else $error("speculative carries inverted"); // R3
    end
  end
endmodule

bind sqrtSelectAdder csaChecker #(
  .FIRST_WIDTH(FIRST_WIDTH),
  .NUM_GROUPS (NUM_GROUPS)
) uChk (
  .opA          (opA),
  .opB          (opB),
  .carryIn      (carryIn),
  .sumOut       (sumOut),
  .carryOut     (carryOut),
  .specCout0    (specCout0),
  .specCout1    (specCout1),
  .boundaryCarry(boundaryCarry)
);

// File: tb/sim_sqrtSelectAdder.sv
`timescale 1ns/1ps
module sim_sqrtSelectAdder;
  localparam int WIDTH = 20;

  logic             clk = 1'b0;
  logic [WIDTH-1:0] a   = '0;
  logic [WIDTH-1:0] b   = '0;
  logic             cin = 1'b0;
  logic [WIDTH-1:0] s;
  logic             co;
  int               nChecks  = 0;
  int               nFails   = 0;
  bit               finished = 1'b0;

  // Group starts (independent of the RTL package): 0, 2, 5, 9, 14; widths 2..6
  int grpStart [5] = '{0, 2, 5, 9, 14};
  int grpW     [5] = '{2, 3, 4, 5, 6};

  always #2 clk = ~clk;  // 250 MHz

  sqrtSelectAdder u0 (
    .opA     (a),
    .opB     (b),
    .carryIn (cin),
    .sumOut  (s),
    .carryOut(co)
  );

  task automatic checkOne(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y,
                          input logic ci, input string req);
    logic [WIDTH:0] expv;
    @(negedge clk);
    a = x; b = y; cin = ci;
    @(posedge clk);
    #1;
    expv = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci};
    nChecks++;
    if ({co, s} !== expv) begin
      nFails++;
      $display("FAIL %s: a=%h b=%h cin=%b actual=%h expected=%h", req, x, y, ci, {co, s}, expv);
    end
  endtask

  task automatic testQuiescent();
    checkOne('0, '0, 1'b0, "R1 zero operands");
  endtask

  task automatic testLowestGroup();
    checkOne('0, '0, 1'b1, "R5 carry-in alone");
    checkOne(20'h3, '0, 1'b1, "R5 carry out of bit 1 into bit 2");
    checkOne(20'h1, 20'h1, 1'b0, "R5 generate inside lowest group");
    checkOne(20'h2, 20'h2, 1'b1, "R5 generate at bit 1 plus carry-in");
  endtask

  task automatic testBoundaries();
    for (int i = 1; i < 5; i++) begin
      int L = grpStart[i];
      // ripple from carry-in across all lower bits into boundary L
      checkOne(WIDTH'((1 << L) - 1), '0, 1'b1, "R2 ripple into boundary");
      // carry generated in top bit of previous group
      checkOne(WIDTH'(1 << (L - 1)), WIDTH'(1 << (L - 1)), 1'b0, "R2 generate at group top");
      // bit just below boundary propagates, no carry: must not cross
      checkOne(WIDTH'(1 << (L - 1)), '0, 1'b0, "R4 no false carry at boundary");
    end
  endtask

  task automatic testSpeculative();
    for (int i = 1; i < 5; i++) begin
      int L = grpStart[i];
      int W = grpW[i];
      logic [WIDTH-1:0] grpOnes = WIDTH'(((1 << W) - 1) << L);
      logic [WIDTH-1:0] below   = WIDTH'((1 << L) - 1);
      // all-propagate group, incoming carry 0 then 1
      checkOne(grpOnes, '0, 1'b0, "R3 propagate group, carry 0");
      checkOne(grpOnes | below, '0, 1'b1, "R3 propagate group, carry 1");
      // all-generate group, incoming carry 0 then 1
      checkOne(grpOnes, grpOnes, 1'b0, "R3 generate group, carry 0");
      checkOne(grpOnes | below, grpOnes, 1'b1, "R3 generate group, carry 1");
    end
  endtask

  task automatic testFullPropagate();
    checkOne(20'hAAAAA, 20'h55555, 1'b0, "R7 all propagate, carry 0");
    checkOne(20'hAAAAA, 20'h55555, 1'b1, "R7 all propagate, carry 1");
    checkOne(20'hFFFFF, 20'h00000, 1'b1, "R7 carry through every group");
  endtask

  task automatic testCarryOut();
    checkOne(20'h80000, 20'h80000, 1'b0, "R6 top bit generate");
    checkOne(20'hFFFFF, 20'hFFFFF, 1'b1, "R6 maximum operands");
    checkOne(20'h7FFFF, 20'h00001, 1'b0, "R6 no carry-out below limit");
    checkOne(20'hFFFFF, 20'h00001, 1'b0, "R6 exact overflow");
  endtask

  task automatic testRandom();
    for (int n = 0; n < 3000; n++) begin
      logic [WIDTH-1:0] x = WIDTH'($urandom);
      logic [WIDTH-1:0] y;
      case (n % 3)
        0: y = ~x ^ WIDTH'(1 << ($urandom % WIDTH));
        1: y = ~x;
        default: y = WIDTH'($urandom);
      endcase
      checkOne(x, y, 1'($urandom), "R1 random sum");
    end
  endtask

  task automatic printSummary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL R1 watchdog: actual=running expected=done");
      printSummary();
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    testQuiescent();
    testLowestGroup();
    testBoundaries();
    testSpeculative();
    testFullPropagate();
    testCarryOut();
    testRandom();
    finished = 1'b1;
    printSummary();
    $finish;
  end
endmodule